// File: doc/BRIEF.md
# Windowed Command and Status Register Front End

This block sits between a host bus and the core of a small network controller. The host writes 16-bit command words to one fixed offset. Each word is split into a 5-bit opcode and an 11-bit argument. The block checks the argument and then either applies the command or drops it. A dropped command raises a sticky error flag. A read at the same offset returns a status word that carries the current register window, the in-progress flag and eight sticky event bits. Accesses at any other offset are passed to a register-select output, tagged with the current window, so that the controller's register banks can decode them.

Internal state covers the register window (0 to 6), the interrupt-enable and statistics-enable flags, an 8-bit interrupt mask and an in-progress flag. Three commands start a timed operation. While that operation runs, the in-progress flag stays set for a parameterised number of cycles and every command is refused. Each accepted command also appears on a strobe with its opcode and argument, so that the core can act on commands this block does not interpret itself.

Top module: `cmdwin_front`

## Requirements
- R1: A command write is a cycle with host_acc=1, host_wr=1 and host_addr=CMD_OFS. Bits 15:11 of host_wdata are the opcode and bits 10:0 are the argument. An accepted command drives cmd_fire=1, with cmd_op and cmd_arg equal to those fields, in the same cycle.
- R2: Opcode 1 (select window) with an argument from 0 to 6 loads the window. The new value appears in status bits 15:13 after the next clock edge. The window never holds a value above 6.
- R3: Opcodes 0 (global reset), 8 (receive discard) and 11 (transmit reset) raise busy, which is also status bit 12. Busy stays high for exactly BUSY_CYCLES cycles and then clears by itself.
- R4: A command write while busy is 1 is not accepted and has no effect on state. It sets cmd_err from the next cycle onward, and cmd_err stays set until rst.
- R5: A command with an illegal argument or an undefined opcode is ignored and sets cmd_err. The defined opcodes are 0-5, 8-19 and 21-24. Opcodes 0, 2-5, 8-11 and 21-23 require argument 0. Opcode 1 requires an argument of 6 or less. Opcodes 14 and 15 require an argument below 129. Opcode 16 requires an argument below 15. Opcodes 12, 13, 17-19 and 24 accept any argument.
- R6: Opcode 14 (interrupt mask) loads int_mask with argument bits 7:0. It sets int_en to 1 when the argument is nonzero and clears int_en when the argument is zero.
- R7: Opcode 21 sets stats_en and opcode 22 clears it.
- R8: Event bits 7:0 are sticky. evt_set sets any of them. Opcode 12 sets bit 6 (interrupt requested). Opcode 13 clears the bits selected by argument bits 7:0. When a set and a clear of the same bit fall in one cycle, the bit ends up set.
- R9: The status word is {window[2:0], busy, 4'b0000, events[7:0]}, and bits 11:8 always read as zero.
- R10: irq is 1 exactly when int_en is 1 and some event bit is set whose int_mask bit is also set.
- R11: An access with host_acc=1 at any offset other than CMD_OFS drives sel_valid=1, sel_win equal to the current window and sel_ofs equal to host_addr, in the same cycle. An access at CMD_OFS never drives sel_valid.
- R12: An accepted global reset command sets the window to 0, clears int_en, stats_en, int_mask and all events (except those set by evt_set in the same cycle), and leaves cmd_err unchanged.
- R13: After rst, window, busy, int_en, stats_en, int_mask, events and cmd_err are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_acc | input | 1 | Host access strobe |
| host_wr | input | 1 | Access is a write |
| host_addr | input | ADDR_W | Host offset |
| host_wdata | input | 16 | Host write data |
| evt_set | input | 8 | Event set pulses from the core |
| status_word | output | 16 | Window, busy, reserved zeros, events |
| busy | output | 1 | Timed operation in progress |
| int_en | output | 1 | Interrupts enabled |
| stats_en | output | 1 | Statistics enabled |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Masked interrupt request |
| cmd_err | output | 1 | Sticky refused-command flag |
| cmd_fire | output | 1 | Accepted command strobe |
| cmd_op | output | 5 | Accepted opcode |
| cmd_arg | output | 11 | Accepted argument |
| sel_valid | output | 1 | Windowed register access |
| sel_win | output | 3 | Window for that access |
| sel_ofs | output | ADDR_W | Offset for that access |

## Verification
An acknowledge command can clear an event bit in the same cycle that the core pulses evt_set for that bit. The acknowledge should lose, so the event is not dropped. The bench sets up this clash directly, acknowledging every bit while setting some of them, and also lets it happen by chance during the random run. The event bits that result are compared with a model in which the set is applied after the clear. A second clash is a command that arrives in the last busy cycle. The model refuses it, and cmd_err must rise.

// File: rtl/cmdwin_pkg.sv
package cmdwin_pkg;

    localparam int CMD_W  = 16;
    localparam int OP_W   = 5;
    localparam int ARG_W  = 11;
    localparam int WIN_W  = 3;
    localparam int EV_W   = 8;
    localparam int WIN_MAX = 6;
    localparam int EV_IRQ_REQ = 6;

    typedef enum logic [OP_W-1:0] {
        OP_GRESET   = 5'd0,  OP_SELWIN   = 5'd1,  OP_COAX_ON  = 5'd2,
        OP_RX_OFF   = 5'd3,  OP_RX_ON    = 5'd4,  OP_RX_RST   = 5'd5,
        OP_RX_DROP  = 5'd8,  OP_TX_ON    = 5'd9,  OP_TX_OFF   = 5'd10,
        OP_TX_RST   = 5'd11, OP_IRQ_REQ  = 5'd12, OP_IRQ_ACK  = 5'd13,
        OP_INT_MASK = 5'd14, OP_RZ_MASK  = 5'd15, OP_RX_FILT  = 5'd16,
        OP_RX_EARLY = 5'd17, OP_TX_AVAIL = 5'd18, OP_TX_START = 5'd19,
        OP_STAT_ON  = 5'd21, OP_STAT_OFF = 5'd22, OP_COAX_OFF = 5'd23,
        OP_TX_RECL  = 5'd24
    } opcode_e;

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ARG_W-1:0] arg;
    } cmd_t;

    typedef struct packed {
        logic greset;
        logic selwin;
        logic busy_start;
        logic irq_req;
        logic irq_ack;
        logic mask_wr;
        logic stats_on;
        logic stats_off;
    } act_t;

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic             busy;
        logic [3:0]       rsv;
        logic [EV_W-1:0]  ev;
    } status_t;

    function automatic logic arg_ok(input logic [OP_W-1:0] op, input logic [ARG_W-1:0] arg);
        logic ok;
        case (op)
            OP_GRESET, OP_COAX_ON, OP_RX_OFF, OP_RX_ON, OP_RX_RST,
            OP_RX_DROP, OP_TX_ON, OP_TX_OFF, OP_TX_RST,
            OP_STAT_ON, OP_STAT_OFF, OP_COAX_OFF:  ok = (arg == '0);
            OP_SELWIN:                             ok = (arg <= ARG_W'(WIN_MAX));
            OP_INT_MASK, OP_RZ_MASK:               ok = (arg < ARG_W'(129));
            OP_RX_FILT:                            ok = (arg < ARG_W'(15));
            OP_IRQ_REQ, OP_IRQ_ACK, OP_RX_EARLY,
            OP_TX_AVAIL, OP_TX_START, OP_TX_RECL:  ok = 1'b1;
            default:                               ok = 1'b0;
        endcase
        return ok;
    endfunction

    function automatic logic starts_busy(input logic [OP_W-1:0] op);
        return (op == OP_GRESET) || (op == OP_RX_DROP) || (op == OP_TX_RST);
    endfunction

endpackage

// File: rtl/cmdwin_decode.sv
module cmdwin_decode
    import cmdwin_pkg::*;
(
    input  logic             cmd_wr,
    input  logic             busy,
    input  logic [CMD_W-1:0] wdata,
    output logic             accept,
    output logic             reject,
    output cmd_t             cmd,
    output act_t             act
);

    logic legal;

    always_comb begin
        cmd    = cmd_t'(wdata);
        legal  = arg_ok(cmd.op, cmd.arg);
        accept = cmd_wr && !busy && legal;
        reject = cmd_wr && !accept;
    end

    always_comb begin
        act = '0;
        if (accept) begin
            act.busy_start = starts_busy(cmd.op);
            case (cmd.op)
                OP_GRESET:   act.greset    = 1'b1;
                OP_SELWIN:   act.selwin    = 1'b1;
                OP_IRQ_REQ:  act.irq_req   = 1'b1;
                OP_IRQ_ACK:  act.irq_ack   = 1'b1;
                OP_INT_MASK: act.mask_wr   = 1'b1;
                OP_STAT_ON:  act.stats_on  = 1'b1;
                OP_STAT_OFF: act.stats_off = 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cmdwin_busy.sv
module cmdwin_busy #(
    parameter int BUSY_CYCLES = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

    logic [CNT_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            left <= '0;
        end else if (start) begin
            busy <= 1'b1;
            left <= LOAD;
        end else if (busy) begin
            if (left == '0) busy <= 1'b0;
            else            left <= left - 1'b1;
        end
    end

endmodule

// File: rtl/cmdwin_events.sv
module cmdwin_events #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_in,
    input  logic [W-1:0] clr_in,
    output logic [W-1:0] ev
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)            ev[i] <= 1'b0;
            else if (set_in[i]) ev[i] <= 1'b1;
            else if (clr_in[i]) ev[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/cmdwin_front.sv
module cmdwin_front
    import cmdwin_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int CMD_OFS     = 14,
    parameter int BUSY_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_acc,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    input  logic [7:0]        evt_set,
    output logic [15:0]       status_word,
    output logic              busy,
    output logic              int_en,
    output logic              stats_en,
    output logic [7:0]        int_mask,
    output logic              irq,
    output logic              cmd_err,
    output logic              cmd_fire,
    output logic [4:0]        cmd_op,
    output logic [10:0]       cmd_arg,
    output logic              sel_valid,
    output logic [2:0]        sel_win,
    output logic [ADDR_W-1:0] sel_ofs
);

    localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CMD_OFS);

    logic             at_cmd, cmd_wr, accept, reject;
    cmd_t             cmd;
    act_t             act;
    logic [WIN_W-1:0] window;
    logic [EV_W-1:0]  ev, ev_set, ev_clr;
    status_t          st;

    assign at_cmd = (host_addr == CMD_ADDR);
    assign cmd_wr = host_acc && host_wr && at_cmd;

    cmdwin_decode u_dec (
        .cmd_wr (cmd_wr),
        .busy   (busy),
        .wdata  (host_wdata),
        .accept (accept),
        .reject (reject),
        .cmd    (cmd),
        .act    (act)
    );

    cmdwin_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk   (clk),
        .rst   (rst),
        .start (act.busy_start),
        .busy  (busy)
    );

    always_comb begin
        ev_set = evt_set;
        if (act.irq_req) ev_set[EV_IRQ_REQ] = 1'b1;
        if (act.greset)       ev_clr = '1;
        else if (act.irq_ack) ev_clr = cmd.arg[EV_W-1:0];
        else                  ev_clr = '0;
    end

    cmdwin_events #(.W(EV_W)) u_ev (
        .clk    (clk),
        .rst    (rst),
        .set_in (ev_set),
        .clr_in (ev_clr),
        .ev     (ev)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            window   <= '0;
            int_en   <= 1'b0;
            stats_en <= 1'b0;
            int_mask <= '0;
            cmd_err  <= 1'b0;
        end else begin
            if (reject) cmd_err <= 1'b1;
            if (act.greset) begin
                window   <= '0;
                int_en   <= 1'b0;
                stats_en <= 1'b0;
                int_mask <= '0;
            end
            if (act.selwin)    window   <= cmd.arg[WIN_W-1:0];
            if (act.mask_wr) begin
                int_mask <= cmd.arg[EV_W-1:0];
                int_en   <= (cmd.arg != '0);
            end
            if (act.stats_on)  stats_en <= 1'b1;
            if (act.stats_off) stats_en <= 1'b0;
        end
    end

    always_comb begin
        st.win  = window;
        st.busy = busy;
        st.rsv  = '0;
        st.ev   = ev;
    end
    assign status_word = st;

    assign irq = int_en && ((ev & int_mask) != '0);

    assign cmd_fire = accept;
    assign cmd_op   = cmd.op;
    assign cmd_arg  = cmd.arg;

    assign sel_valid = host_acc && !at_cmd;
    assign sel_win   = window;
    assign sel_ofs   = host_addr;

endmodule

// File: rtl/cmdwin_chk.sv
module cmdwin_chk #(
    parameter int ADDR_W      = 4,
    parameter int CMD_OFS     = 14,
    parameter int BUSY_CYCLES = 20
) (
    input logic              clk,
    input logic              rst,
    input logic              host_acc,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [7:0]        evt_set,
    input logic [15:0]       status_word,
    input logic              busy,
    input logic              int_en,
    input logic              irq,
    input logic              cmd_err,
    input logic              cmd_fire,
    input logic              sel_valid,
    input logic [ADDR_W-1:0] sel_ofs
);

    logic wr_cmd;
    int   run;

    assign wr_cmd = host_acc && host_wr && (host_addr == ADDR_W'(CMD_OFS));

    always_ff @(posedge clk) begin
        if (rst || !busy) run <= 0;
        else              run <= run + 1;
    end

    // R2
    win_range_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[15:13] <= 3'd6);

    // R2
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_fire |=> $stable(status_word[15:13]));

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run < BUSY_CYCLES));

    // R4
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && busy) |-> !cmd_fire);

    // R4
    busy_err_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd && busy) |=> cmd_err);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_set != 8'd0) |=> ((status_word[7:0] & $past(evt_set)) == $past(evt_set)));

    // R9
    rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
        status_word[11:8] == 4'd0);

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> int_en);

    // R11
    sel_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (sel_ofs != ADDR_W'(CMD_OFS)));

endmodule

bind cmdwin_front cmdwin_chk #(
    .ADDR_W(ADDR_W), .CMD_OFS(CMD_OFS), .BUSY_CYCLES(BUSY_CYCLES)
) u_chk (
    .clk(clk), .rst(rst), .host_acc(host_acc), .host_wr(host_wr),
    .host_addr(host_addr), .evt_set(evt_set), .status_word(status_word),
    .busy(busy), .int_en(int_en), .irq(irq), .cmd_err(cmd_err),
    .cmd_fire(cmd_fire), .sel_valid(sel_valid), .sel_ofs(sel_ofs)
);

// File: tb/tb_cmdwin_front.sv
module tb_cmdwin_front;

    localparam int BC  = 6;
    localparam int CMD = 14;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_acc, host_wr;
    logic [3:0]  host_addr;
    logic [15:0] host_wdata;
    logic [7:0]  evt_set;
    logic [15:0] status_word;
    logic        busy, int_en, stats_en, irq, cmd_err, cmd_fire, sel_valid;
    logic [7:0]  int_mask;
    logic [4:0]  cmd_op;
    logic [10:0] cmd_arg;
    logic [2:0]  sel_win;
    logic [3:0]  sel_ofs;

    always #5 clk = ~clk;

    cmdwin_front #(.ADDR_W(4), .CMD_OFS(CMD), .BUSY_CYCLES(BC)) dut (
        .clk(clk), .rst(rst), .host_acc(host_acc), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .evt_set(evt_set),
        .status_word(status_word), .busy(busy), .int_en(int_en),
        .stats_en(stats_en), .int_mask(int_mask), .irq(irq), .cmd_err(cmd_err),
        .cmd_fire(cmd_fire), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
        .sel_valid(sel_valid), .sel_win(sel_win), .sel_ofs(sel_ofs)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    int       m_win, m_left;
    bit       m_busy, m_int, m_stats, m_err;
    bit [7:0] m_mask, m_evt;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit legal(bit [4:0] op, bit [10:0] a);
        case (op)
            0, 2, 3, 4, 5, 8, 9, 10, 11, 21, 22, 23: return a == 0;
            1:                                       return a <= 6;
            14, 15:                                  return a < 129;
            16:                                      return a < 15;
            12, 13, 17, 18, 19, 24:                  return 1'b1;
            default:                                 return 1'b0;
        endcase
    endfunction

    function automatic bit [15:0] exp_status();
        return {m_win[2:0], m_busy, 4'b0000, m_evt};
    endfunction

    task automatic check_regs();
        chk("R9", "status_word", status_word, exp_status());
        chk("R3", "busy", busy, m_busy);
        chk("R6", "int_en/int_mask", {int_en, int_mask}, {m_int, m_mask});
        chk("R7", "stats_en", stats_en, m_stats);
        chk("R5", "cmd_err", cmd_err, m_err);
        chk("R10", "irq", irq, m_int && ((m_evt & m_mask) != 0));
    endtask

    task automatic cyc(bit acc, bit wr, bit [3:0] addr, bit [15:0] data, bit [7:0] ev);
        bit       iscmd, fire;
        bit [7:0] clr, setv;
        @(negedge clk);
        check_regs();
        host_acc = acc; host_wr = wr; host_addr = addr; host_wdata = data; evt_set = ev;
        #1;
        iscmd = acc && wr && (addr == CMD);
        fire  = iscmd && !m_busy && legal(data[15:11], data[10:0]);
        chk("R1", "cmd_fire", cmd_fire, fire);
        if (fire) chk("R1", "cmd_op/cmd_arg", {cmd_op, cmd_arg}, data);
        chk("R11", "sel_valid", sel_valid, acc && (addr != CMD));
        if (sel_valid) chk("R11", "sel_win/sel_ofs", {sel_win, sel_ofs}, {m_win[2:0], addr});
        clr = 0; setv = ev;
        if (m_busy) begin
            if (m_left == 0) m_busy = 0; else m_left--;
        end
        if (iscmd && !fire) m_err = 1;
        if (fire) begin
            case (data[15:11])
                0: begin
                    m_win = 0; m_int = 0; m_stats = 0; m_mask = 0; clr = 8'hff;
                    m_busy = 1; m_left = BC - 1;
                end
                8, 11: begin m_busy = 1; m_left = BC - 1; end
                1:  m_win = int'(data[2:0]);
                12: setv = setv | 8'h40;
                13: clr = data[7:0];
                14: begin m_int = (data[10:0] != 0); m_mask = data[7:0]; end
                21: m_stats = 1;
                22: m_stats = 0;
                default: ;
            endcase
        end
        m_evt = (m_evt & ~clr) | setv;
    endtask

    task automatic cmdw(bit [4:0] op, bit [10:0] a, bit [7:0] ev = 0);
        cyc(1, 1, 4'(CMD), {op, a}, ev);
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        int nb;
        void'($urandom(32'd4711));
        host_acc = 0; host_wr = 0; host_addr = 0; host_wdata = 0; evt_set = 0;
        rst = 1;
        m_win = 0; m_left = 0; m_busy = 0; m_int = 0; m_stats = 0; m_err = 0;
        m_mask = 0; m_evt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R13: reset state
        chk("R13", "status after reset", status_word, 16'h0000);
        chk("R13", "flags after reset", {busy, int_en, stats_en, cmd_err, int_mask}, 0);

        // R2: window select, top legal value
        cmdw(1, 6); idle();
        chk("R2", "window=6", status_word[15:13], 3'd6);
        // R11: routed access carries the window
        cyc(1, 0, 4'd10, 0, 0);
        // R7
        cmdw(21, 0); idle();
        chk("R7", "stats on", stats_en, 1'b1);
        // R6: mask 128 enables interrupts with bit 7 only
        cmdw(14, 128); idle();
        chk("R6", "mask 128", {int_en, int_mask}, 9'h180);
        // R10: event bit 7 raises irq, bit 0 does not
        cyc(0, 0, 0, 0, 8'h01); idle();
        chk("R10", "unmasked event", irq, 1'b0);
        cyc(0, 0, 0, 0, 8'h80); idle();
        chk("R10", "masked event", irq, 1'b1);
        // R8: acknowledge all while bit 3 is set in the same cycle
        cmdw(13, 11'h0ff, 8'h08); idle();
        chk("R8", "set beats clear", status_word[7:0], 8'h08);
        cmdw(12, 0); idle();
        chk("R8", "irq request bit6", status_word[7:0], 8'h48);
        // R6: zero mask disables
        cmdw(14, 0); idle();
        chk("R6", "mask zero", int_en, 1'b0);
        // R5: illegal argument and undefined opcode keep state, raise error
        cmdw(1, 7); idle();
        chk("R5", "window kept", status_word[15:13], 3'd6);
        chk("R5", "error raised", cmd_err, 1'b1);
        cmdw(20, 0); cmdw(16, 15); cmdw(14, 129); idle();
        chk("R5", "mask kept", {int_en, int_mask}, 9'h000);
        // R3 / R12: global reset, busy length
        cmdw(14, 3); cmdw(0, 0);
        nb = 0;
        for (int i = 0; i < BC + 4; i++) begin
            idle();
            if (busy) nb++;
            if (i == 0) begin
                chk("R12", "state after global reset",
                    {status_word[15:13], int_en, stats_en, int_mask, status_word[7:0]}, 0);
                chk("R12", "error kept", cmd_err, 1'b1);
            end
        end
        chk("R3", "busy length", nb, BC);
        // R4: command during busy is dropped
        cmdw(11, 0);
        for (int i = 0; i < BC - 1; i++) idle();
        cmdw(1, 2); idle();
        chk("R4", "window unchanged under busy", status_word[15:13], 3'd0);
        idle(); cmdw(1, 2); idle();
        chk("R2", "window after busy", status_word[15:13], 3'd2);

        // random mix, model compares every cycle
        for (int i = 0; i < 3000; i++) begin
            bit [4:0]  op;
            bit [10:0] a;
            bit [3:0]  ad;
            op = 5'($urandom % 32);
            a  = ($urandom % 4 == 0) ? 11'($urandom % 2048) : 11'($urandom % 8);
            ad = ($urandom % 10 < 7) ? 4'(CMD) : 4'($urandom % 16);
            cyc($urandom % 4 != 0, $urandom % 4 != 0, ad, {op, a},
                ($urandom % 6 == 0) ? 8'($urandom) : 8'h00);
        end
        idle();
        finish_run();
    end

endmodule